// File: doc/BRIEF.md
# Triple-Redundant Voted Shift Register

This block is a long serial delay line in which every stage is held in three flip-flops and read through a majority voter. It is meant to sit next to an unprotected chain of the same length and the same combinational padding between stages, so that the upset rates of the two can be compared. A serial bit is first taken in by two plain, non-redundant capture flops. It then passes through the voted stages and leaves through one plain output flop. Between every pair of stages a chain of gates is inserted. The gates can be inverters, two-input AND gates with one input held high, or two-input OR gates with one input held low, or the chain can be left out. The default is eight gates per chain, which leaves the data unchanged.

The block checks itself. It keeps a plain copy of the serial input, delayed by the same number of shifts, and compares the output with it on every shift once the chain has filled. Mismatches are counted. It also watches every stage for copies that disagree. This is reported through a registered flag and a second counter that increments once per clock while any disagreement is present. An upset-emulation port flips one chosen copy of one chosen stage, so that the voting and the counters can be exercised.

Top module: `tmr_voted_shreg`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `sout`, `err_cnt`, `mis_cnt` and `mis_flag` are all zero, because every copy, capture flop, output flop and counter is cleared.
- R2: A bit presented on `sin` at a clock edge where `en` is high appears on `sout` after STAGES+3 enabled edges, counting its own capture edge. That is two capture flops, STAGES voted stages and one output flop.
- R3: On an edge where `en` is low, no stage, capture flop or output flop changes, so `sout` holds its value. The only exception is a copy targeted by an upset request.
- R4: With the default depth of eight gates per chain, every gate kind gives the same output sequence: GATE_NONE=0, GATE_NOT=1, GATE_AND=2, GATE_OR=3. An odd number of inverters per chain inverts the data once per stage.
- R5: A single flipped copy in a stage never changes `sout`. The next enabled edge reloads all three copies with the voted value of the previous stage.
- R6: `mis_flag` is high in the cycle after any cycle in which some stage's three copies differ. `mis_cnt` increments by one at every such clock edge, whatever the state of `en`, and saturates at its maximum.
- R7: `err_cnt` increments by one at each enabled edge where the chain has already completed STAGES+3 enabled edges and `sout` differs from the input delayed by the same amount. It never changes before the chain is filled or on an edge where `en` is low. It saturates at its maximum.
- R8: An upset request (`inj_valid` high at an edge) inverts the copy numbered `inj_copy` (0, 1 or 2) of stage `inj_stage` (0 is nearest the input). A request with `inj_copy`=3 or `inj_stage`≥STAGES has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Shift enable |
| sin | input | 1 | Serial data input |
| inj_valid | input | 1 | Upset request |
| inj_stage | input | SEL_W | Stage targeted by the upset request |
| inj_copy | input | 2 | Copy targeted (0..2; 3 means no copy) |
| sout | output | 1 | Serial output from the non-redundant output flop |
| err_cnt | output | CNT_W | Output mismatches seen after fill |
| mis_cnt | output | CNT_W | Clock cycles with a copy disagreement |
| mis_flag | output | 1 | Registered disagreement flag |

## Verification
The hardest situation to reach is a stage whose voter itself delivers a wrong bit. One flipped copy is always outvoted, so an output error needs two copies of the same stage corrupted before the next shift. The stimulus gets there by holding `en` low and issuing two upset requests to different copies of one stage on consecutive edges. It then resumes shifting and expects exactly one counted output error when that bit reaches `sout`, STAGES minus the stage index further shifts later. The rest of the stimulus is random data with random enable gaps, and single upsets injected in stalls. These single upsets must raise the flag and the disagreement count while leaving the output and the error count untouched.

// File: rtl/tmr_sr_pkg.sv
package tmr_sr_pkg;

  typedef enum logic [1:0] {
    GATE_NONE = 2'd0,
    GATE_NOT  = 2'd1,
    GATE_AND  = 2'd2,
    GATE_OR   = 2'd3
  } gate_kind_e;

  // majority of three copies
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // true when three copies are not all equal
  function automatic logic split3(input logic a, input logic b, input logic c);
    return (a ^ b) | (b ^ c);
  endfunction

  // does one inter-stage chain invert the data
  function automatic logic chain_inverts(input gate_kind_e kind, input int depth);
    return (kind == GATE_NOT) && (depth % 2 == 1);
  endfunction

  // net inversion from input to output across all stages
  function automatic logic path_inverts(input gate_kind_e kind, input int depth,
                                        input int stages);
    return chain_inverts(kind, depth) && (stages % 2 == 1);
  endfunction

  // enabled edges from capture to output: two capture flops, stages, output flop
  function automatic int path_latency(input int stages);
    return stages + 3;
  endfunction

  // saturating increment
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input int width);
    logic [31:0] top_v;
    top_v = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    return (v >= top_v) ? top_v : v + 32'd1;
  endfunction

endpackage

// File: rtl/tmr_gate_chain.sv
module tmr_gate_chain
  import tmr_sr_pkg::*;
#(
  parameter gate_kind_e KIND  = GATE_NOT,
  parameter int         DEPTH = 8
) (
  input  logic a_in,
  output logic y_out
);

  generate
    if (KIND == GATE_NONE || DEPTH == 0) begin : g_wire
      assign y_out = a_in;
    end else begin : g_chain
      logic [DEPTH:0] node;
      logic           tie_hi;
      logic           tie_lo;
      assign tie_hi  = 1'b1;
      assign tie_lo  = 1'b0;
      assign node[0] = a_in;
      for (genvar g = 0; g < DEPTH; g++) begin : g_gate
        if (KIND == GATE_NOT) begin : g_inv
          assign node[g+1] = ~node[g];
        end else if (KIND == GATE_AND) begin : g_and
          assign node[g+1] = node[g] & tie_hi;
        end else begin : g_or
          assign node[g+1] = node[g] | tie_lo;
        end
      end
      assign y_out = node[DEPTH];
    end
  endgenerate

endmodule

// File: rtl/tmr_stage.sv
module tmr_stage
  import tmr_sr_pkg::*;
#(
  parameter gate_kind_e KIND  = GATE_NOT,
  parameter int         DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       d_in,
  input  logic       inj_hit,
  input  logic [1:0] inj_copy,
  output logic       voted,
  output logic       disagree
);

  logic       d_gated;
  logic [2:0] cp;
  logic [2:0] cp_nxt;
  logic       flip_now;

  tmr_gate_chain #(.KIND(KIND), .DEPTH(DEPTH)) u_gates (
    .a_in  (d_in),
    .y_out (d_gated)
  );

  assign flip_now = inj_hit && (inj_copy != 2'd3);

  always_comb begin
    cp_nxt = en ? {3{d_gated}} : cp;
    if (flip_now) cp_nxt[inj_copy] = ~cp_nxt[inj_copy];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cp <= 3'b000;
    else        cp <= cp_nxt;
  end

  assign voted    = maj3(cp[0], cp[1], cp[2]);
  assign disagree = split3(cp[0], cp[1], cp[2]);

  AST_RELOAD_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !flip_now) |=> (cp[0] == cp[1]) && (cp[1] == cp[2])) else $error("stage copies differ after reload"); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !flip_now) |=> $stable(cp)) else $error("stage moved while stalled"); // R3

  AST_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && flip_now) |=> ($countones(cp ^ $past(cp)) == 1)) else $error("upset changed other than one copy"); // R8

endmodule

// File: rtl/tmr_chk_monitor.sv
module tmr_chk_monitor
  import tmr_sr_pkg::*;
#(
  parameter int LAT   = 353,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sin,
  input  logic             sout_q,
  input  logic             out_invert,
  input  logic             disagree_any,
  output logic [CNT_W-1:0] err_cnt,
  output logic [CNT_W-1:0] mis_cnt,
  output logic             mis_flag
);

  localparam int FILL_W = $clog2(LAT + 1);

  logic [LAT-1:0]    ref_sr;
  logic [FILL_W-1:0] fill_cnt;
  logic              filled;
  logic              ref_bit;
  logic              out_bad;

  assign filled  = (fill_cnt == FILL_W'(LAT));
  assign ref_bit = ref_sr[LAT-1] ^ out_invert;
  assign out_bad = en && filled && (sout_q != ref_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sr   <= '0;
      fill_cnt <= '0;
    end else if (en) begin
      ref_sr <= {ref_sr[LAT-2:0], sin};
      if (!filled) fill_cnt <= fill_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt  <= '0;
      mis_cnt  <= '0;
      mis_flag <= 1'b0;
    end else begin
      mis_flag <= disagree_any;
      if (out_bad)      err_cnt <= CNT_W'(sat_inc(32'(err_cnt), CNT_W));
      if (disagree_any) mis_cnt <= CNT_W'(sat_inc(32'(mis_cnt), CNT_W));
    end
  end

  AST_ERR_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !filled |=> $stable(err_cnt)) else $error("error counted during fill"); // R7

  AST_ERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(err_cnt)) else $error("error counted while stalled"); // R7

  AST_FLAG_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    mis_flag |-> (mis_cnt != '0)) else $error("flag set with empty count"); // R6

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !mis_flag |-> (mis_cnt == $past(mis_cnt))) else $error("count moved without flag"); // R6

endmodule

// File: rtl/tmr_voted_shreg.sv
module tmr_voted_shreg
  import tmr_sr_pkg::*;
#(
  parameter int         STAGES = 350,
  parameter gate_kind_e KIND   = GATE_NOT,
  parameter int         DEPTH  = 8,
  parameter int         CNT_W  = 16,
  parameter int         SEL_W  = $clog2(STAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sin,
  input  logic             inj_valid,
  input  logic [SEL_W-1:0] inj_stage,
  input  logic [1:0]       inj_copy,
  output logic             sout,
  output logic [CNT_W-1:0] err_cnt,
  output logic [CNT_W-1:0] mis_cnt,
  output logic             mis_flag
);

  localparam int   LAT        = path_latency(STAGES);
  localparam logic OUT_INVERT = path_inverts(KIND, DEPTH, STAGES);

  logic              cap_a;
  logic              cap_b;
  logic              out_q;
  logic [STAGES:0]   link;
  logic [STAGES-1:0] split_vec;
  logic              disagree_any;

  // non-redundant input capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= 1'b0;
      cap_b <= 1'b0;
    end else if (en) begin
      cap_a <= sin;
      cap_b <= cap_a;
    end
  end

  assign link[0] = cap_b;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic hit;
      assign hit = inj_valid && (inj_stage == SEL_W'(i));
      tmr_stage #(.KIND(KIND), .DEPTH(DEPTH)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .d_in     (link[i]),
        .inj_hit  (hit),
        .inj_copy (inj_copy),
        .voted    (link[i+1]),
        .disagree (split_vec[i])
      );
    end
  endgenerate

  assign disagree_any = |split_vec;

  // non-redundant output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  out_q <= 1'b0;
    else if (en) out_q <= link[STAGES];
  end

  assign sout = out_q;

  tmr_chk_monitor #(.LAT(LAT), .CNT_W(CNT_W)) u_mon (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .sin          (sin),
    .sout_q       (out_q),
    .out_invert   (OUT_INVERT),
    .disagree_any (disagree_any),
    .err_cnt      (err_cnt),
    .mis_cnt      (mis_cnt),
    .mis_flag     (mis_flag)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(sout)) else $error("output moved while stalled"); // R3

  AST_FLAG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    disagree_any |=> mis_flag) else $error("disagreement not flagged"); // R6

  AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cap_b)) else $error("capture moved while stalled"); // R3

endmodule

// File: tb/tmr_voted_shreg_tb_top.sv
module tmr_voted_shreg_tb_top;
  import tmr_sr_pkg::*;

  localparam int STAGES = 350;
  localparam int CW     = 16;
  localparam int SW     = 9;
  localparam int LAT_TB = STAGES + 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          sin = 1'b0;
  logic          inj_valid = 1'b0;
  logic [SW-1:0] inj_stage = '0;
  logic [1:0]    inj_copy = 2'd0;
  logic          sout_not, sout_none, sout_and, sout_or;
  logic [CW-1:0] err_not, err_none, err_and, err_or;
  logic [CW-1:0] mis_not, mis_none, mis_and, mis_or;
  logic          flag_not, flag_none, flag_and, flag_or;

  always #5 clk = ~clk;

  tmr_voted_shreg #(.STAGES(STAGES), .KIND(GATE_NOT), .DEPTH(8), .CNT_W(CW), .SEL_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .sin(sin), .inj_valid(inj_valid),
    .inj_stage(inj_stage), .inj_copy(inj_copy), .sout(sout_not),
    .err_cnt(err_not), .mis_cnt(mis_not), .mis_flag(flag_not));

  tmr_voted_shreg #(.STAGES(STAGES), .KIND(GATE_NONE), .DEPTH(8), .CNT_W(CW), .SEL_W(SW)) dut_none (
    .clk(clk), .rst_n(rst_n), .en(en), .sin(sin), .inj_valid(1'b0),
    .inj_stage('0), .inj_copy(2'd0), .sout(sout_none),
    .err_cnt(err_none), .mis_cnt(mis_none), .mis_flag(flag_none));

  tmr_voted_shreg #(.STAGES(STAGES), .KIND(GATE_AND), .DEPTH(8), .CNT_W(CW), .SEL_W(SW)) dut_and (
    .clk(clk), .rst_n(rst_n), .en(en), .sin(sin), .inj_valid(1'b0),
    .inj_stage('0), .inj_copy(2'd0), .sout(sout_and),
    .err_cnt(err_and), .mis_cnt(mis_and), .mis_flag(flag_and));

  tmr_voted_shreg #(.STAGES(STAGES), .KIND(GATE_OR), .DEPTH(8), .CNT_W(CW), .SEL_W(SW)) dut_or (
    .clk(clk), .rst_n(rst_n), .en(en), .sin(sin), .inj_valid(1'b0),
    .inj_stage('0), .inj_copy(2'd0), .sout(sout_or),
    .err_cnt(err_or), .mis_cnt(mis_or), .mis_flag(flag_or));

  int   checks = 0;
  int   fails  = 0;
  bit   hist [0:8191];
  bit   flp  [0:8191];
  int   k = 0;
  int   exp_err = 0;
  int   exp_mis = 0;
  bit   exp_flag = 1'b0;
  bit   [2:0] mask = 3'b000;
  int   pend_s = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at k=%0d", req, act, expv, k);
    end
  endtask

  // sample index seen at the output after kk enabled edges
  function automatic bit exp_out(input int kk, input bit with_flip);
    int idx;
    idx = kk - STAGES - 2;
    if (idx < 1) return 1'b0;
    return hist[idx] ^ (with_flip & flp[idx]);
  endfunction

  function automatic bit copies_split(input bit [2:0] m);
    return (m != 3'b000) && (m != 3'b111);
  endfunction

  task automatic step(input bit e, input bit s, input bit iv, input int ist, input int icp);
    bit dis_before;
    bit valid_inj;
    @(negedge clk);
    en        = e;
    sin       = s;
    inj_valid = iv;
    inj_stage = ist[SW-1:0];
    inj_copy  = icp[1:0];
    dis_before = copies_split(mask);
    valid_inj  = iv && (ist < STAGES) && (icp < 3);
    @(posedge clk);
    exp_flag = dis_before;
    if (dis_before) exp_mis++;
    if (e) begin
      if (k >= LAT_TB && flp[k - STAGES - 2]) exp_err++;
      if ($countones(mask) >= 2) flp[k - 2 - pend_s] = ~flp[k - 2 - pend_s];
      mask = 3'b000;
      k++;
      hist[k] = s;
    end else if (valid_inj) begin
      pend_s = ist;
      mask[icp] = ~mask[icp];
    end
    #2;
    chk(sout_not  == exp_out(k, 1'b1), "R2 sout", int'(sout_not), int'(exp_out(k, 1'b1)));
    chk(sout_none == exp_out(k, 1'b0), "R4 none", int'(sout_none), int'(exp_out(k, 1'b0)));
    chk(sout_and  == exp_out(k, 1'b0), "R4 and",  int'(sout_and),  int'(exp_out(k, 1'b0)));
    chk(sout_or   == exp_out(k, 1'b0), "R4 or",   int'(sout_or),   int'(exp_out(k, 1'b0)));
    chk(int'(err_not) == exp_err, "R7 err_cnt", int'(err_not), exp_err);
    chk(flag_not == exp_flag, "R6 mis_flag", int'(flag_not), int'(exp_flag));
    chk(int'(mis_not) == exp_mis, "R6 mis_cnt", int'(mis_not), exp_mis);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    for (int i = 0; i < 8192; i++) begin hist[i] = 1'b0; flp[i] = 1'b0; end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(sout_not == 1'b0 && sout_or == 1'b0, "R1 sout", int'(sout_not), 0);
    chk(err_not == '0, "R1 err_cnt", int'(err_not), 0);
    chk(mis_not == '0 && flag_not == 1'b0, "R1 mis", int'(mis_not), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sout_not == 1'b0 && err_not == '0 && flag_not == 1'b0, "R1 after release", int'(sout_not), 0);

    // R2: single one travels the chain
    step(1'b1, 1'b1, 1'b0, 0, 0);
    for (int i = 0; i < LAT_TB + 4; i++) step(1'b1, 1'b0, 1'b0, 0, 0);

    // R3: stall with toggling input
    for (int i = 0; i < 6; i++) step(1'b0, i[0], 1'b0, 0, 0);

    // random traffic with enable gaps and single upsets (R5)
    for (int i = 0; i < 1500; i++) begin
      bit e, s;
      e = ($urandom % 4) != 0;
      s = $urandom % 2;
      if (($urandom % 40) == 0 && mask == 3'b000)
        step(1'b0, s, 1'b1, int'($urandom % STAGES), int'($urandom % 3));
      else
        step(e, s, 1'b0, 0, 0);
    end
    step(1'b1, 1'b0, 1'b0, 0, 0);

    // R5: directed single upset then stall, then shift
    step(1'b0, 1'b0, 1'b1, 100, 2);
    step(1'b0, 1'b1, 1'b0, 0, 0);
    step(1'b0, 1'b0, 1'b0, 0, 0);
    chk(flag_not == 1'b1, "R5 flag during upset", int'(flag_not), 1);
    step(1'b1, 1'b1, 1'b0, 0, 0);
    step(1'b1, 1'b0, 1'b0, 0, 0);
    chk(flag_not == 1'b0, "R5 flag after reload", int'(flag_not), 0);

    // R8: ignored requests
    begin
      int mis_before;
      mis_before = int'(mis_not);
      step(1'b0, 1'b0, 1'b1, 5, 3);
      step(1'b0, 1'b0, 1'b1, STAGES + 10, 1);
      step(1'b0, 1'b0, 1'b0, 0, 0);
      chk(flag_not == 1'b0 && int'(mis_not) == mis_before, "R8 ignored upset", int'(mis_not), mis_before);
    end

    // R7: double upset near the output and near the input
    begin
      int err_before;
      err_before = exp_err;
      step(1'b0, 1'b0, 1'b1, STAGES - 5, 0);
      step(1'b0, 1'b0, 1'b1, STAGES - 5, 1);
      for (int i = 0; i < 20; i++) step(1'b1, ($urandom % 2) == 1, 1'b0, 0, 0);
      step(1'b0, 1'b0, 1'b1, 0, 2);
      step(1'b0, 1'b0, 1'b1, 0, 1);
      for (int i = 0; i < STAGES + 10; i++) step(1'b1, ($urandom % 2) == 1, 1'b0, 0, 0);
      chk(exp_err == err_before + 2, "R7 model count", exp_err, err_before + 2);
      chk(int'(err_not) == err_before + 2, "R7 two voter faults", int'(err_not), err_before + 2);
      chk(err_none == '0 && err_and == '0 && err_or == '0, "R7 clean chains", int'(err_or), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule